// File: doc/BRIEF.md
# Bus-Master DMA Channel Register Block

This block keeps the host-visible control state of one bus-master DMA channel. A host register port reads and writes three registers: a control byte, a condition byte and a 32-bit descriptor-list pointer. Writes that flip the run bit of the control byte become one-cycle start or abort requests to a separate DMA engine. A start request carries the pointer value that applies when the transfer begins. The engine reports back through a completion pulse and a fault pulse, and the block turns these into condition bits and an interrupt line.

The condition byte combines three kinds of bit. Some are read-only, some are cleared by writing a one, and some are plain storage. A global bus-master enable input gates all writes. While it is low, the register file cannot be changed but can still be read. A write of the wrong width to a known register does not change any state and raises a one-cycle error pulse.

Top module: `bmdma_chan_regs`

## Requirements
- R1: After reset the control byte reads 0x00, the condition byte reads 0x60 and the pointer reads 0x00000000. No request or error pulse is high, and `irq` is low.
- R2: A byte write (`req_size`=0) to offset 0 stores bit 0 (run) and bit 3 (direction). When run goes from 0 to 1, the active bit is set and `start_req` pulses in the next cycle, with `start_ptr` equal to the stored pointer. When run goes from 1 to 0, active is cleared and `abort_req` pulses. A write that leaves run unchanged gives no pulse. Direction can be written at any time.
- R3: Bit 0 of the condition byte (active) ignores host writes.
- R4: Condition bit 1 (fault) and bit 2 (interrupt) are cleared by a byte write at offset 2 that has a 1 in that bit. A 0 in that bit leaves it unchanged. Bits 5 and 6 are plain read/write storage. Bits 3, 4 and 7 read as 0.
- R5: The pointer at offset 4 accepts only word writes (`req_size`=2). Its two low bits are always stored as zero.
- R6: A write with the wrong size is an error. This covers a non-byte write at offset 0 or 2, a non-word write at offset 4, and the size code 3. On such a write, `size_err` pulses for one cycle and no register changes.
- R7: A `dma_done` pulse clears run and active and sets the interrupt bit. A `dma_fault` pulse sets the fault bit, and it wins over a write-one-to-clear in the same cycle.
- R8: If `dma_done` arrives in the same cycle as a host write, the completion wins. Run and active end at 0 and the interrupt bit ends at 1. No start or abort request is issued in that cycle.
- R9: While `bm_en` is low, every write is dropped, including an illegal-size write, which raises no error. Reads still return the register contents.
- R10: `irq` equals the interrupt bit of the condition byte.
- R11: `rd_data` is combinational. Offsets 0 to 3 form the word {0x00, condition, 0x00, control}, offsets 4 to 7 form the pointer, and the word is shifted right by 8 times the offset modulo 4. Writes to offsets 1, 3, 5, 6 and 7 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bm_en | input | 1 | Global bus-master enable; writes are dropped while low |
| req_valid | input | 1 | Register access valid this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 3 | Byte offset within the channel register window |
| req_size | input | 2 | 0 = byte, 1 = half, 2 = word, 3 = illegal |
| req_wdata | input | 32 | Write data, byte 0 in bits 7:0 |
| rd_data | output | 32 | Read data for req_addr |
| dma_done | input | 1 | Completion pulse from the DMA engine |
| dma_fault | input | 1 | Fault pulse from the DMA engine |
| start_req | output | 1 | One-cycle transfer start request |
| abort_req | output | 1 | One-cycle transfer abort request |
| start_ptr | output | 32 | Pointer captured with the start request |
| size_err | output | 1 | One-cycle illegal-size write flag |
| irq | output | 1 | Interrupt pending |

## Verification
The engine's completion pulse and a host write can land in the same cycle. The tricky overlaps are completion with a run 0→1 write from idle, completion with a run 1→0 write during a transfer, and completion with an interrupt-clearing condition write. Each of these is driven on purpose. The bench then checks that no request pulse leaves the block, that run and active end at 0, and that the interrupt bit stays set. A fault pulse is also placed in the same cycle as a write that clears the fault bit, and the bit must stay set. The reference model applies the host write first and the engine event second, and the bench compares the model with the design on every clock.

// File: rtl/bmdma_pkg.sv
package bmdma_pkg;
  // register byte offsets
  localparam int OFF_CTRL = 0;
  localparam int OFF_COND = 2;
  localparam int OFF_PTR  = 4;

  // control byte fields
  localparam int CTRL_RUN = 0;
  localparam int CTRL_DIR = 3;

  // condition byte fields
  localparam int COND_ACT  = 0;
  localparam int COND_FLT  = 1;
  localparam int COND_INT  = 2;
  localparam int COND_CAP0 = 5;
  localparam int COND_CAP1 = 6;

  localparam logic [1:0] CAP_RESET = 2'b11;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_BAD  = 2'd3
  } acc_size_e;
endpackage

// File: rtl/bmdma_rst_sync.sv
module bmdma_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/bmdma_wr_decode.sv
module bmdma_wr_decode
  import bmdma_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bm_en,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  output logic              ctrl_we,
  output logic              cond_we,
  output logic              ptr_we,
  output logic              size_err
);
  logic acc, hit_ctrl, hit_cond, hit_ptr;
  logic byte_ok, word_ok, err_d, err_q;

  always_comb begin
    acc      = req_valid && req_write && bm_en;
    hit_ctrl = (req_addr == ADDR_W'(OFF_CTRL));
    hit_cond = (req_addr == ADDR_W'(OFF_COND));
    hit_ptr  = (req_addr == ADDR_W'(OFF_PTR));
    byte_ok  = (req_size == SZ_BYTE);
    word_ok  = (req_size == SZ_WORD);
    ctrl_we  = acc && hit_ctrl && byte_ok;
    cond_we  = acc && hit_cond && byte_ok;
    ptr_we   = acc && hit_ptr  && word_ok;
    err_d    = acc && ((hit_ctrl && !byte_ok) ||
                       (hit_cond && !byte_ok) ||
                       (hit_ptr  && !word_ok));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_d;
  end

  assign size_err = err_q;
endmodule

// File: rtl/bmdma_ctl_regs.sv
module bmdma_ctl_regs
  import bmdma_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctrl_we,
  input  logic       cond_we,
  input  logic       wr_run,
  input  logic       wr_dir,
  input  logic       wr_flt,
  input  logic       wr_int,
  input  logic [1:0] wr_cap,
  input  logic       dma_done,
  input  logic       dma_fault,
  output logic [7:0] ctrl_byte,
  output logic [7:0] cond_byte,
  output logic       start_fire,
  output logic       active,
  output logic       int_pend,
  output logic       start_req,
  output logic       abort_req
);
  logic       run_q, dir_q, act_q, flt_q, int_q;
  logic [1:0] cap_q;
  logic       run_d, dir_d, act_d, flt_d, int_d;
  logic [1:0] cap_d;
  logic       abort_fire, upd_en;
  logic       start_req_q, abort_req_q;

  // next state: host write first, engine events last (they win)
  always_comb begin
    run_d      = run_q;
    dir_d      = dir_q;
    act_d      = act_q;
    flt_d      = flt_q;
    int_d      = int_q;
    cap_d      = cap_q;
    start_fire = 1'b0;
    abort_fire = 1'b0;
    if (ctrl_we) begin
      run_d = wr_run;
      dir_d = wr_dir;
      if (!dma_done) begin
        if (!run_q && wr_run) begin
          start_fire = 1'b1;
          act_d      = 1'b1;
        end else if (run_q && !wr_run) begin
          abort_fire = 1'b1;
          act_d      = 1'b0;
        end
      end
    end
    if (cond_we) begin
      if (wr_flt) flt_d = 1'b0;
      if (wr_int) int_d = 1'b0;
      cap_d = wr_cap;
    end
    if (dma_fault) flt_d = 1'b1;
    if (dma_done) begin
      run_d = 1'b0;
      act_d = 1'b0;
      int_d = 1'b1;
    end
    upd_en = ctrl_we || cond_we || dma_fault || dma_done;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      dir_q <= 1'b0;
      act_q <= 1'b0;
      flt_q <= 1'b0;
      int_q <= 1'b0;
      cap_q <= CAP_RESET;
    end else if (upd_en) begin
      run_q <= run_d;
      dir_q <= dir_d;
      act_q <= act_d;
      flt_q <= flt_d;
      int_q <= int_d;
      cap_q <= cap_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_req_q <= 1'b0;
      abort_req_q <= 1'b0;
    end else begin
      start_req_q <= start_fire;
      abort_req_q <= abort_fire;
    end
  end

  always_comb begin
    ctrl_byte           = '0;
    ctrl_byte[CTRL_RUN] = run_q;
    ctrl_byte[CTRL_DIR] = dir_q;
    cond_byte            = '0;
    cond_byte[COND_ACT]  = act_q;
    cond_byte[COND_FLT]  = flt_q;
    cond_byte[COND_INT]  = int_q;
    cond_byte[COND_CAP0] = cap_q[0];
    cond_byte[COND_CAP1] = cap_q[1];
  end

  assign active    = act_q;
  assign int_pend  = int_q;
  assign start_req = start_req_q;
  assign abort_req = abort_req_q;
endmodule

// File: rtl/bmdma_ptr_reg.sv
module bmdma_ptr_reg #(
  parameter int PTR_W     = 32,
  parameter int ALIGN_LSB = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ptr_we,
  input  logic [PTR_W-1:0] wdata,
  input  logic             start_fire,
  output logic [PTR_W-1:0] ptr,
  output logic [PTR_W-1:0] start_ptr
);
  localparam logic [PTR_W-1:0] ALIGN_MASK = ~((PTR_W'(1) << ALIGN_LSB) - PTR_W'(1));

  logic [PTR_W-1:0] ptr_q, ptr_d, sptr_q;

  always_comb ptr_d = wdata & ALIGN_MASK;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_we) ptr_q <= ptr_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          sptr_q <= '0;
    else if (start_fire) sptr_q <= ptr_q;
  end

  assign ptr       = ptr_q;
  assign start_ptr = sptr_q;
endmodule

// File: rtl/bmdma_chan_regs.sv
module bmdma_chan_regs
  import bmdma_pkg::*;
#(
  parameter int ADDR_W      = 3,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bm_en,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [DATA_W-1:0] rd_data,
  input  logic              dma_done,
  input  logic              dma_fault,
  output logic              start_req,
  output logic              abort_req,
  output logic [DATA_W-1:0] start_ptr,
  output logic              size_err,
  output logic              irq
);
  localparam int LANE_W = 2;

  logic              rst_i_n;
  logic              ctrl_we, cond_we, ptr_we, start_fire;
  logic              cs_active, cs_int;
  logic [7:0]        ctrl_byte, cond_byte;
  logic [DATA_W-1:0] ptr_val, rd_word;

  bmdma_rst_sync #(.STAGES(SYNC_STAGES)) i_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n)
  );

  bmdma_wr_decode #(.ADDR_W(ADDR_W)) i_dec (
    .clk(clk), .rst_n(rst_i_n), .bm_en(bm_en), .req_valid(req_valid),
    .req_write(req_write), .req_addr(req_addr), .req_size(req_size),
    .ctrl_we(ctrl_we), .cond_we(cond_we), .ptr_we(ptr_we), .size_err(size_err)
  );

  bmdma_ctl_regs i_ctl (
    .clk(clk), .rst_n(rst_i_n), .ctrl_we(ctrl_we), .cond_we(cond_we),
    .wr_run(req_wdata[CTRL_RUN]), .wr_dir(req_wdata[CTRL_DIR]),
    .wr_flt(req_wdata[COND_FLT]), .wr_int(req_wdata[COND_INT]),
    .wr_cap({req_wdata[COND_CAP1], req_wdata[COND_CAP0]}),
    .dma_done(dma_done), .dma_fault(dma_fault),
    .ctrl_byte(ctrl_byte), .cond_byte(cond_byte), .start_fire(start_fire),
    .active(cs_active), .int_pend(cs_int),
    .start_req(start_req), .abort_req(abort_req)
  );

  bmdma_ptr_reg #(.PTR_W(DATA_W), .ALIGN_LSB(2)) i_ptr (
    .clk(clk), .rst_n(rst_i_n), .ptr_we(ptr_we), .wdata(req_wdata),
    .start_fire(start_fire), .ptr(ptr_val), .start_ptr(start_ptr)
  );

  always_comb begin
    rd_word = '0;
    if (req_addr[ADDR_W-1:LANE_W] == '0)
      rd_word = DATA_W'({8'h00, cond_byte, 8'h00, ctrl_byte});
    else if (req_addr[ADDR_W-1:LANE_W] == (ADDR_W-LANE_W)'(1))
      rd_word = ptr_val;
    rd_data = rd_word >> {req_addr[LANE_W-1:0], 3'b000};
  end

  assign irq = cs_int;
endmodule

// File: rtl/bmdma_chan_chk.sv
module bmdma_chan_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bm_en,
  input logic        req_valid,
  input logic        req_write,
  input logic        dma_done,
  input logic        cond_we,
  input logic        active,
  input logic        start_req,
  input logic        abort_req,
  input logic [31:0] start_ptr,
  input logic        size_err,
  input logic        irq
);
  AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_req, abort_req})); // R2

  AST_START_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    start_req |-> active); // R2

  AST_ACTIVE_RO: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_we && !dma_done) |=> (active == $past(active))); // R3

  AST_PTR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    start_req |-> (start_ptr[1:0] == 2'b00)); // R5

  AST_DONE_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    dma_done |=> (irq && !active)); // R7

  AST_DONE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    dma_done |=> (!start_req && !abort_req)); // R8

  AST_GATED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (!bm_en && req_valid && req_write) |=> (!size_err && !start_req && !abort_req)); // R9
endmodule

bind bmdma_chan_regs bmdma_chan_chk i_chk (
  .clk(clk), .rst_n(rst_n), .bm_en(bm_en), .req_valid(req_valid),
  .req_write(req_write), .dma_done(dma_done), .cond_we(cond_we),
  .active(cs_active), .start_req(start_req), .abort_req(abort_req),
  .start_ptr(start_ptr), .size_err(size_err), .irq(irq)
);

// File: tb/test_bmdma_chan_regs.sv
`timescale 1ns/1ps
module test_bmdma_chan_regs;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bm_en, req_valid, req_write, dma_done, dma_fault;
  logic [2:0]  req_addr;
  logic [1:0]  req_size;
  logic [31:0] req_wdata, rd_data, start_ptr;
  logic        start_req, abort_req, size_err, irq;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;

  // reference state
  bit m_run, m_dir, m_act, m_flt, m_int;
  bit [1:0] m_cap;
  bit [31:0] m_ptr, m_sptr;
  bit e_start, e_abort, e_err;

  always #4 clk = ~clk;

  bmdma_chan_regs i_bmdma_chan_regs (
    .clk(clk), .rst_n(rst_n), .bm_en(bm_en), .req_valid(req_valid),
    .req_write(req_write), .req_addr(req_addr), .req_size(req_size),
    .req_wdata(req_wdata), .rd_data(rd_data), .dma_done(dma_done),
    .dma_fault(dma_fault), .start_req(start_req), .abort_req(abort_req),
    .start_ptr(start_ptr), .size_err(size_err), .irq(irq)
  );

  function automatic bit [31:0] model_read(input int a);
    bit [31:0] w;
    bit [7:0] c, s;
    c = {4'b0, m_dir, 2'b0, m_run};
    s = {1'b0, m_cap, 2'b0, m_int, m_flt, m_act};
    if (a < 4) w = {8'h00, s, 8'h00, c};
    else       w = m_ptr;
    return w >> (8 * (a % 4));
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic model_step(input bit v, input bit w, input int a, input int sz,
                            input bit [31:0] d, input bit done, input bit flt, input bit en);
    e_start = 0; e_abort = 0; e_err = 0;
    if (v && w && en) begin
      if (a == 0) begin
        if (sz != 0) e_err = 1;
        else begin
          if (!done) begin
            if (!m_run && d[0]) begin e_start = 1; m_act = 1; m_sptr = m_ptr; end
            else if (m_run && !d[0]) begin e_abort = 1; m_act = 0; end
          end
          m_run = d[0]; m_dir = d[3];
        end
      end else if (a == 2) begin
        if (sz != 0) e_err = 1;
        else begin
          if (d[1]) m_flt = 0;
          if (d[2]) m_int = 0;
          m_cap = d[6:5];
        end
      end else if (a == 4) begin
        if (sz != 2) e_err = 1;
        else m_ptr = d & 32'hFFFF_FFFC;
      end
    end
    if (flt) m_flt = 1;
    if (done) begin m_run = 0; m_act = 0; m_int = 1; end
  endtask

  // one clock: drive at negedge, check read, clock, check registered outputs
  task automatic cyc(input string tag, input bit v, input bit w, input int a,
                     input int sz, input bit [31:0] d, input bit done = 0,
                     input bit flt = 0, input bit en = 1);
    req_valid = v; req_write = w; req_addr = 3'(a); req_size = 2'(sz);
    req_wdata = d; dma_done = done; dma_fault = flt; bm_en = en;
    #1;
    check(tag, "rd_data", rd_data, model_read(a));
    @(posedge clk);
    model_step(v, w, a, sz, d, done, flt, en);
    @(negedge clk);
    check(tag, "start_req", 32'(start_req), 32'(e_start));
    check(tag, "abort_req", 32'(abort_req), 32'(e_abort));
    check(tag, "size_err", 32'(size_err), 32'(e_err));
    check(tag, "irq", 32'(irq), 32'(m_int));
    if (e_start) check(tag, "start_ptr", start_ptr, m_sptr);
  endtask

  task automatic rd(input string tag, input int a);
    cyc(tag, 1, 0, a, 0, 32'h0);
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    rst_n = 0; bm_en = 1; req_valid = 0; req_write = 0; req_addr = 0;
    req_size = 0; req_wdata = 0; dma_done = 0; dma_fault = 0;
    m_run = 0; m_dir = 0; m_act = 0; m_flt = 0; m_int = 0; m_cap = 2'b11;
    m_ptr = 0; m_sptr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd("R1", 0); rd("R1", 2); rd("R1", 4);

    // R5 pointer alignment
    cyc("R5", 1, 1, 4, 2, 32'h1234_5677);
    rd("R5", 4);

    // R4 capability bits plain storage, reserved bits read 0
    cyc("R4", 1, 1, 2, 0, 32'h0000_0098);
    rd("R4", 2);
    cyc("R4", 1, 1, 2, 0, 32'h0000_0060);

    // R2 start with direction
    cyc("R2", 1, 1, 0, 0, 32'h0000_0009);
    rd("R2", 2);
    // R3 active ignores writes
    cyc("R3", 1, 1, 2, 0, 32'h0000_0060);
    rd("R3", 2);
    // R2 same run value, direction change, no pulse
    cyc("R2", 1, 1, 0, 0, 32'h0000_0001);
    rd("R2", 0);
    // R2 abort
    cyc("R2", 1, 1, 0, 0, 32'h0000_0000);
    rd("R2", 2);
    // R3 writing 1 to active while idle
    cyc("R3", 1, 1, 2, 0, 32'h0000_0061);
    rd("R3", 2);

    // R6 illegal sizes
    cyc("R6", 1, 1, 0, 1, 32'h0000_0001);
    cyc("R6", 1, 1, 2, 2, 32'h0000_0000);
    cyc("R6", 1, 1, 4, 0, 32'hAAAA_AAA8);
    cyc("R6", 1, 1, 4, 1, 32'h5555_5554);
    cyc("R6", 1, 1, 0, 3, 32'h0000_0001);
    rd("R6", 0); rd("R6", 2); rd("R6", 4);

    // R7 start then completion
    cyc("R5", 1, 1, 4, 2, 32'hCAFE_0103);
    cyc("R7", 1, 1, 0, 0, 32'h0000_0001);
    cyc("R7", 0, 0, 0, 0, 32'h0, 1);
    rd("R7", 0); rd("R10", 2);
    // R4 write 0 keeps interrupt, write 1 clears
    cyc("R4", 1, 1, 2, 0, 32'h0000_0060);
    rd("R10", 2);
    cyc("R4", 1, 1, 2, 0, 32'h0000_0064);
    rd("R10", 2);
    // R7 fault set, R4 clear, fault wins over clear
    cyc("R7", 0, 0, 0, 0, 32'h0, 0, 1);
    rd("R7", 2);
    cyc("R4", 1, 1, 2, 0, 32'h0000_0062);
    rd("R4", 2);
    cyc("R7", 0, 0, 0, 0, 32'h0, 0, 1);
    cyc("R7", 1, 1, 2, 0, 32'h0000_0062, 0, 1);
    rd("R7", 2);
    cyc("R4", 1, 1, 2, 0, 32'h0000_0062);

    // R8 completion with interrupt clear
    cyc("R8", 1, 1, 2, 0, 32'h0000_0064, 1);
    rd("R8", 2);
    cyc("R8", 1, 1, 2, 0, 32'h0000_0064);
    // R8 completion with start from idle: no start
    cyc("R8", 1, 1, 0, 0, 32'h0000_0001, 1);
    rd("R8", 0); rd("R8", 2);
    // R8 completion with abort during transfer: no abort
    cyc("R8", 1, 1, 0, 0, 32'h0000_0001);
    cyc("R8", 1, 1, 0, 0, 32'h0000_0000, 1);
    rd("R8", 0); rd("R8", 2);
    cyc("R8", 1, 1, 2, 0, 32'h0000_0064);

    // R9 writes dropped when disabled, reads still served
    cyc("R9", 1, 1, 0, 0, 32'h0000_0009, 0, 0, 0);
    cyc("R9", 1, 1, 4, 2, 32'h0BAD_F00C, 0, 0, 0);
    cyc("R9", 1, 1, 2, 2, 32'h0000_0000, 0, 0, 0);
    cyc("R9", 1, 1, 2, 0, 32'h0000_0000, 0, 0, 0);
    cyc("R9", 1, 0, 4, 0, 32'h0, 0, 0, 0);
    cyc("R9", 1, 0, 2, 0, 32'h0, 0, 0, 0);
    rd("R9", 0);

    // R11 unmapped offsets ignored, byte-lane reads
    cyc("R11", 1, 1, 1, 0, 32'h0000_00FF);
    cyc("R11", 1, 1, 3, 0, 32'h0000_00FF);
    cyc("R11", 1, 1, 6, 1, 32'h0000_FFFF);
    cyc("R11", 1, 1, 7, 0, 32'h0000_00FF);
    for (int a = 0; a < 8; a++) rd("R11", a);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule